// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs a single read or write transfer on an external bus where one set of 16 pins carries both the address and the data, and four further pins carry both the top address bits and cycle status. The pin functions change from one bus state to the next. An internal requester presents a transfer: a 20-bit address, a direction, a memory-or-I/O choice, a byte or word size, write data, a segment code and the interrupt-enable flag. The sequencer then walks through the bus states and drives every external control line. When the transfer finishes it returns the read data and a one-cycle completion pulse.

The bus states are named as follows.

- `ST_IDLE` waits for a request.
- `ST_T1` is the address phase, with the address latch strobe high.
- `ST_T2` and `ST_T3` are the first data-phase states, with the read or write strobe low.
- `ST_TW` is a wait state that repeats while the ready input stays low.
- `ST_T4` is the closing state, which raises `done`.

The transitions are as follows.

- `ST_IDLE` to `ST_T1` when a request is presented.
- `ST_T1` to `ST_T2` to `ST_T3` unconditionally.
- `ST_T3` to `ST_T4` if ready is high at the end of `ST_T3`, otherwise `ST_T3` to `ST_TW`.
- `ST_TW` to `ST_T4` when ready is sampled high, otherwise it stays in `ST_TW`.
- `ST_T4` to `ST_IDLE` unconditionally.

The bus has two byte lanes. Which lanes are active is decided by the address LSB together with the size, and is signalled on an active-low high-lane enable pin. During the data phases that same pin carries a status bit.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset and while idle, the outputs rest at these values: `rd_n`, `wr_n`, `den_n` and `bhe_n` high; `ale`, `ad_oe`, `done` and `mem_sel` low.
- R2: A request seen with `req_valid` high while idle is accepted on that clock edge. In the next cycle (T1), `ale` is high for exactly one cycle, and `ad_o` carries address bits 15..0 with `ad_oe` high.
- R3: In T1, `as_o` carries address bits 19..16 for a memory transfer (`req_mem`=1) and 4'b0000 for an I/O transfer.
- R4: From T2 through T4, `as_o` = {1'b0, interrupt-enable flag, segment code} and `bhe_n` is high. The segment codes are: 2'b00 alternate data, 2'b01 stack, 2'b10 code, 2'b11 data.
- R5: In T1, `bhe_n` is set by the size (`req_word`=1 for a word) and address bit 0 (`ad_o[0]`):
  - word at an even address: `bhe_n`=0 with `ad_o[0]`=0;
  - byte at an odd address: `bhe_n`=0 with `ad_o[0]`=1;
  - byte at an even address: `bhe_n`=1 with `ad_o[0]`=0;
  - word at an odd address: moves the odd (upper-lane) byte only, and is signalled like an odd byte.
- R6: A read holds `rd_n` low from T2 through the last T3/wait state, with `ad_oe` low, `dtr` low and `den_n` low. `rd_data` is captured on the edge that ends the last T3/wait state and is shown in T4. The captured value is aligned by access type:
  - even word: `ad_i` as it is;
  - odd byte: {8'h00, `ad_i[15:8]`};
  - even byte: {8'h00, `ad_i[7:0]`}.
- R7: A write holds `wr_n` low from T2 through the last T3/wait state, with `dtr` high and `den_n` low. `ad_oe` stays high from T2 through T4. `ad_o` carries the write data for an even word; for a byte it carries the low data byte copied onto both lanes.
- R8: `rdy` is sampled at the end of T3 and at the end of each wait state. Each low sample adds one wait state, during which every bus output holds its data-phase value.
- R9: In T4, `done` is high for one cycle and `rd_n`, `wr_n` and `den_n` are high. The next cycle is idle.
- R10: A `req_valid` seen while a transfer is in progress is ignored. No further T1 follows the current transfer.
- R11: `mem_sel` is high from T1 through T4 for a memory transfer and low for an I/O transfer. `dtr` equals the direction (1 write, 0 read) from T1 through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_addr | input | 20 | Transfer address |
| req_wr | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_word | input | 1 | 1 word, 0 byte |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment code shown in status |
| req_ie | input | 1 | Interrupt-enable flag shown in status |
| rd_data | output | 16 | Aligned read data, valid from T4 |
| done | output | 1 | One-cycle completion pulse in T4 |
| ad_i | input | 16 | Shared address/data lines, sampled value |
| ad_o | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| as_o | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mem_sel | output | 1 | 1 memory, 0 I/O |
| dtr | output | 1 | Transceiver direction, 1 = outbound |
| den_n | output | 1 | Transceiver enable, active low |
| bhe_n | output | 1 | High-lane enable in T1, status (high) afterwards |
| rdy | input | 1 | Ready; a low sample inserts a wait state |

## Verification
Several rules hold on every cycle and are checked by the assertions:
- the one-cycle `ale` pulse;
- `rd_n` and `wr_n` never low together;
- the direction, drive-enable and transceiver-enable levels that go with each strobe;
- `bhe_n` high while a strobe is active;
- zero upper lines in an I/O address phase;
- strobes held across a low ready sample;
- a single `done` pulse with the strobes released.

Other behaviour depends on the request that was presented, so only the directed scenarios can show it:
- the address, status and lane-enable values;
- the byte alignment of captured read data and the lane copying of write data;
- the exact number of wait states;
- a request arriving mid-transfer being dropped.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    // Bus states of one transfer
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_t;

    // Segment code carried on the status lines
    typedef enum logic [1:0] {
        SEG_ALT   = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_t;

    // Status field positions on the upper lines
    localparam int unsigned ST_SEG_LSB = 0;
    localparam int unsigned ST_IE_BIT  = 2;

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       rdy,
    input  logic       lat_wr,
    input  logic       lat_mem,
    output bus_state_t state,
    output logic       accept,
    output logic       capture,
    output logic       ale,
    output logic       rd_n,
    output logic       wr_n,
    output logic       den_n,
    output logic       dtr,
    output logic       mem_sel,
    output logic       done
);

    bus_state_t state_q;
    bus_state_t state_d;
    logic       strobe_ph;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = rdy ? ST_T4 : ST_TW;
            ST_TW:   state_d = rdy ? ST_T4 : ST_TW;
            ST_T4:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign state   = state_q;
    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = ((state_q == ST_T3) || (state_q == ST_TW)) && rdy;

    // Output decode
    always_comb begin
        ale       = 1'b0;
        strobe_ph = 1'b0;
        dtr       = 1'b1;
        mem_sel   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                dtr = 1'b1;
            end
            ST_T1: begin
                ale     = 1'b1;
                dtr     = lat_wr;
                mem_sel = lat_mem;
            end
            ST_T2, ST_T3, ST_TW: begin
                strobe_ph = 1'b1;
                dtr       = lat_wr;
                mem_sel   = lat_mem;
            end
            ST_T4: begin
                dtr     = lat_wr;
                mem_sel = lat_mem;
                done    = 1'b1;
            end
            default: begin
                dtr = 1'b1;
            end
        endcase
        rd_n  = !(strobe_ph && !lat_wr);
        wr_n  = !(strobe_ph && lat_wr);
        den_n = !strobe_ph;
    end

endmodule

// File: rtl/mbus_req_reg.sv
module mbus_req_reg
    import mbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic              req_mem,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  seg_t              req_seg,
    input  logic              req_ie,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_wr,
    output logic              lat_mem,
    output logic              lat_word,
    output logic [DATA_W-1:0] lat_wdata,
    output seg_t              lat_seg,
    output logic              lat_ie
);

    // Request fields are held for the whole transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wr    <= 1'b0;
            lat_mem   <= 1'b0;
            lat_word  <= 1'b0;
            lat_wdata <= '0;
            lat_seg   <= SEG_ALT;
            lat_ie    <= 1'b0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wr    <= req_wr;
            lat_mem   <= req_mem;
            lat_word  <= req_word;
            lat_wdata <= req_wdata;
            lat_seg   <= req_seg;
            lat_ie    <= req_ie;
        end
    end

endmodule

// File: rtl/mbus_lane.sv
module mbus_lane
    import mbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bus_state_t               state,
    input  logic                     capture,
    input  logic [ADDR_W-1:0]        lat_addr,
    input  logic                     lat_wr,
    input  logic                     lat_mem,
    input  logic                     lat_word,
    input  logic [DATA_W-1:0]        lat_wdata,
    input  seg_t                     lat_seg,
    input  logic                     lat_ie,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_o,
    output logic                     bhe_n,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int unsigned HI_W   = ADDR_W - DATA_W;
    localparam int unsigned BYTE_W = DATA_W / 2;

    logic              odd_a;
    logic              full_word;
    logic              lane_hi_n;
    logic              data_ph;
    logic [HI_W-1:0]   status_v;
    logic [DATA_W-1:0] wr_lanes;
    logic [DATA_W-1:0] rd_aligned;
    logic [DATA_W-1:0] rd_q;

    assign odd_a     = lat_addr[0];
    assign full_word = lat_word && !odd_a;
    // The high lane is off only for a byte at an even address
    assign lane_hi_n = !(lat_word || odd_a);
    assign data_ph   = (state == ST_T2) || (state == ST_T3) ||
                       (state == ST_TW) || (state == ST_T4);

    // Status vector: unused upper bits are zero
    always_comb begin
        status_v = '0;
        status_v[ST_SEG_LSB +: 2] = lat_seg;
        status_v[ST_IE_BIT]       = lat_ie;
    end

    // Write lanes: a byte is copied onto both halves
    assign wr_lanes = full_word ? lat_wdata
                                : {2{lat_wdata[BYTE_W-1:0]}};

    // Read alignment by access type
    always_comb begin
        if (full_word) begin
            rd_aligned = ad_i;
        end else if (odd_a) begin
            rd_aligned = {{(DATA_W-BYTE_W){1'b0}}, ad_i[DATA_W-1:BYTE_W]};
        end else begin
            rd_aligned = {{(DATA_W-BYTE_W){1'b0}}, ad_i[BYTE_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (capture && !lat_wr) begin
            rd_q <= rd_aligned;
        end
    end

    assign rd_data = rd_q;

    // Pin function by bus state
    always_comb begin
        ad_o  = '0;
        ad_oe = 1'b0;
        as_o  = '0;
        bhe_n = 1'b1;
        if (state == ST_T1) begin
            ad_o  = lat_addr[DATA_W-1:0];
            ad_oe = 1'b1;
            as_o  = lat_mem ? lat_addr[ADDR_W-1:DATA_W] : '0;
            bhe_n = lane_hi_n;
        end else if (data_ph) begin
            ad_o  = lat_wr ? wr_lanes : '0;
            ad_oe = lat_wr;
            as_o  = status_v;
            bhe_n = 1'b1;
        end
    end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbus_pkg::*;
#(
    parameter  int unsigned ADDR_W = 20,
    parameter  int unsigned DATA_W = 16,
    localparam int unsigned HI_W   = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic              req_mem,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_seg,
    input  logic              req_ie,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [HI_W-1:0]   as_o,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mem_sel,
    output logic              dtr,
    output logic              den_n,
    output logic              bhe_n,
    input  logic              rdy
);

    bus_state_t        state;
    logic              accept;
    logic              capture;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_wr;
    logic              lat_mem;
    logic              lat_word;
    logic [DATA_W-1:0] lat_wdata;
    seg_t              lat_seg;
    logic              lat_ie;

    mbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rdy       (rdy),
        .lat_wr    (lat_wr),
        .lat_mem   (lat_mem),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .den_n     (den_n),
        .dtr       (dtr),
        .mem_sel   (mem_sel),
        .done      (done)
    );

    mbus_req_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_mem   (req_mem),
        .req_word  (req_word),
        .req_wdata (req_wdata),
        .req_seg   (seg_t'(req_seg)),
        .req_ie    (req_ie),
        .lat_addr  (lat_addr),
        .lat_wr    (lat_wr),
        .lat_mem   (lat_mem),
        .lat_word  (lat_word),
        .lat_wdata (lat_wdata),
        .lat_seg   (lat_seg),
        .lat_ie    (lat_ie)
    );

    mbus_lane #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .capture   (capture),
        .lat_addr  (lat_addr),
        .lat_wr    (lat_wr),
        .lat_mem   (lat_mem),
        .lat_word  (lat_word),
        .lat_wdata (lat_wdata),
        .lat_seg   (lat_seg),
        .lat_ie    (lat_ie),
        .ad_i      (ad_i),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .as_o      (as_o),
        .bhe_n     (bhe_n),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/mbus_checks.sv
module mbus_checks #(
    parameter int unsigned HI_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rdy,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            den_n,
    input logic            dtr,
    input logic            ad_oe,
    input logic [HI_W-1:0] as_o,
    input logic            bhe_n,
    input logic            mem_sel,
    input logic            done
);

    // R2: the address latch strobe lasts one cycle
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R6 / R7: the two strobes are never active together
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6: a read strobe goes with an inbound, undriven, enabled transceiver
    a_r6_read_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!dtr && !ad_oe && !den_n));

    // R7: a write strobe goes with an outbound, driven, enabled transceiver
    a_r7_write_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (dtr && ad_oe && !den_n));

    // R4: the lane-enable pin shows status (high) while a strobe is active
    a_r4_s7_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> bhe_n);

    // R3: an I/O address phase keeps the upper lines at zero
    a_r3_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !mem_sel) |-> (as_o == '0));

    // R8: a low ready sample keeps the read strobe active
    a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !rdy) |=> !rd_n);

    // R8: a low ready sample keeps the write strobe active
    a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !rdy) |=> !wr_n);

    // R9: done comes with all strobes released
    a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && den_n && !ale));

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind mux_bus_seq mbus_checks #(.HI_W(HI_W)) u_mbus_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy     (rdy),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .den_n   (den_n),
    .dtr     (dtr),
    .ad_oe   (ad_oe),
    .as_o    (as_o),
    .bhe_n   (bhe_n),
    .mem_sel (mem_sel),
    .done    (done)
);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        req_mem = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_seg = '0;
    logic        req_ie = 1'b0;
    logic [15:0] rd_data;
    logic        done;
    logic [15:0] ad_i = '0;
    logic [15:0] ad_o;
    logic        ad_oe;
    logic [3:0]  as_o;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        mem_sel;
    logic        dtr;
    logic        den_n;
    logic        bhe_n;
    logic        rdy = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;  // 50 MHz

    mux_bus_seq u_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wr(req_wr), .req_mem(req_mem), .req_word(req_word),
        .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie),
        .rd_data(rd_data), .done(done), .ad_i(ad_i), .ad_o(ad_o),
        .ad_oe(ad_oe), .as_o(as_o), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .mem_sel(mem_sel), .dtr(dtr), .den_n(den_n), .bhe_n(bhe_n), .rdy(rdy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Checks the cycle after a request has been presented, through return to idle
    task automatic run_cyc(input string nm, input logic [19:0] a, input logic w,
                           input logic m, input logic wd, input logic [15:0] wdat,
                           input logic [1:0] sg, input logic ie, input int nwait,
                           input logic [15:0] rdv, input logic inject);
        logic [3:0]  stat_e;
        logic [15:0] wr_e;
        logic [15:0] rd_e;
        logic        bhe_e;
        stat_e = {1'b0, ie, sg};
        bhe_e  = !(wd || a[0]);
        wr_e   = (wd && !a[0]) ? wdat : {wdat[7:0], wdat[7:0]};
        rd_e   = (wd && !a[0]) ? rdv : (a[0] ? {8'h00, rdv[15:8]} : {8'h00, rdv[7:0]});

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wr = w; req_mem = m; req_word = wd;
        req_wdata = wdat; req_seg = sg; req_ie = ie;
        @(negedge clk);  // T1
        req_valid = 1'b0;
        chk({"R2 ale in T1 ", nm}, ale, 1'b1);
        chk({"R2 address on shared lines ", nm}, {ad_oe, ad_o}, {1'b1, a[15:0]});
        chk({"R3 upper lines in T1 ", nm}, as_o, m ? a[19:16] : 4'h0);
        chk({"R5 lane enable in T1 ", nm}, bhe_n, bhe_e);
        chk({"R11 select and direction in T1 ", nm}, {mem_sel, dtr}, {m, w});
        chk({"R1 strobes idle in T1 ", nm}, {rd_n, wr_n}, 2'b11);

        @(negedge clk);  // T2
        ad_i = rdv;
        rdy  = (nwait == 0);
        if (inject) begin
            req_valid = 1'b1; req_addr = 20'hABCDE;
        end
        chk({"R2 ale dropped in T2 ", nm}, ale, 1'b0);
        chk({"R4 status in T2 ", nm}, {as_o, bhe_n}, {stat_e, 1'b1});
        chk({"R6R7 strobes in T2 ", nm}, {rd_n, wr_n, den_n, dtr}, {w, !w, 1'b0, w});
        if (w) chk({"R7 write data in T2 ", nm}, {ad_oe, ad_o}, {1'b1, wr_e});
        else   chk({"R6 lines released in T2 ", nm}, ad_oe, 1'b0);

        @(negedge clk);  // T3
        req_valid = 1'b0;
        chk({"R6R7 strobes in T3 ", nm}, {rd_n, wr_n, den_n}, {w, !w, 1'b0});
        chk({"R11 select in T3 ", nm}, mem_sel, m);

        for (int k = 0; k < nwait; k++) begin
            @(negedge clk);  // wait state k
            chk({"R8 wait state holds strobes ", nm}, {rd_n, wr_n, den_n, done}, {w, !w, 1'b0, 1'b0});
            chk({"R8 wait state holds status ", nm}, {as_o, ad_oe}, {stat_e, w});
            rdy = (k == nwait - 1);
        end

        @(negedge clk);  // T4
        rdy = 1'b1;
        chk({"R9 done in T4 ", nm}, {done, rd_n, wr_n, den_n}, 4'b1111);
        chk({"R4 status in T4 ", nm}, {as_o, bhe_n}, {stat_e, 1'b1});
        if (w) chk({"R7 write data held in T4 ", nm}, {ad_oe, ad_o}, {1'b1, wr_e});
        else   chk({"R6 aligned read data ", nm}, rd_data, rd_e);
        ad_i = 16'h0000;

        @(negedge clk);  // idle
        chk({"R9 back to idle ", nm}, {done, ale, ad_oe, mem_sel}, 4'b0000);
        if (!w) chk({"R6 read data held ", nm}, rd_data, rd_e);
        if (inject) begin
            @(negedge clk);
            chk({"R10 no second transfer ", nm}, {ale, ad_oe, rd_n, wr_n}, 4'b0011);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset strobes", {rd_n, wr_n, den_n, bhe_n}, 4'b1111);
        chk("R1 reset lines", {ale, ad_oe, done, mem_sel}, 4'b0000);
    endtask

    task automatic t_word_read();
        run_cyc("mem word read", 20'h5A2C4, 1'b0, 1'b1, 1'b1, 16'h0, 2'b11, 1'b1, 0, 16'hBEEF, 1'b0);
    endtask

    task automatic t_odd_byte_read_wait();
        run_cyc("odd byte read 2 waits", 20'h12345, 1'b0, 1'b1, 1'b0, 16'h0, 2'b01, 1'b0, 2, 16'hC3A5, 1'b0);
    endtask

    task automatic t_io_even_byte_read();
        run_cyc("io even byte read", 20'hF0010, 1'b0, 1'b0, 1'b0, 16'h0, 2'b00, 1'b1, 0, 16'h7E91, 1'b0);
    endtask

    task automatic t_word_write_wait();
        run_cyc("mem word write 1 wait", 20'h9F0A6, 1'b1, 1'b1, 1'b1, 16'h1357, 2'b10, 1'b0, 1, 16'h0, 1'b0);
    endtask

    task automatic t_io_odd_byte_write();
        run_cyc("io odd byte write", 20'h00301, 1'b1, 1'b0, 1'b0, 16'h55AB, 2'b11, 1'b0, 0, 16'h0, 1'b0);
    endtask

    task automatic t_odd_word_read();
        run_cyc("odd word read", 20'h3000F, 1'b0, 1'b1, 1'b1, 16'h0, 2'b10, 1'b1, 0, 16'h6D42, 1'b0);
    endtask

    task automatic t_busy_ignore();
        run_cyc("request while busy", 20'h04020, 1'b0, 1'b1, 1'b0, 16'h0, 2'b01, 1'b1, 1, 16'h1E2F, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_read();
        t_odd_byte_read_wait();
        t_io_even_byte_read();
        t_word_write_wait();
        t_io_odd_byte_write();
        t_odd_word_read();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule